// File: doc/BRIEF.md
# Break-Triggered Wake-Up Detector

This block watches the synchronized receive line of an asynchronous serial port while the port is parked waiting for bus activity, such as the start of a break or a wake-up character on a single-wire bus of the LIN kind. Software arms the monitor with a write strobe. While the monitor is armed it holds the character receiver off. The first falling edge of the line then latches an interrupt flag. The next rising edge disarms the monitor by itself, which hands the line back to the normal receiver once the break is over.

The interrupt flag stays set until software reads the receive data register, which the block sees as a read strobe. Software can also drop the arm bit directly at any moment. This abandons monitoring and raises no interrupt. Edges are found by comparing the synchronized line with a copy delayed by one cycle, so each edge is acted on exactly once.

Top module: `brk_wake_monitor`

## Requirements
- R1: After synchronous reset, `wake_irq`, `armed` and `rx_inhibit` are 0. The stored previous line level resets to the idle level (1), so a low line at reset release counts as a falling edge.
- R2: A cycle with `arm_wr`=1 and `arm_val`=1 while disarmed sets `armed` and `rx_inhibit` to 1 on the next cycle. `rx_inhibit` equals `armed` at all times.
- R3: A falling edge, meaning the line was 1 in the previous cycle and is 0 in this one, while the monitor is armed and waiting for it sets `wake_irq` to 1 on the next cycle. `armed` stays 1.
- R4: After the wake event, the first rising edge (previous 0, now 1) clears `armed` and `rx_inhibit` on the next cycle.
- R5: A cycle with `rd_stb`=1 and no wake event clears `wake_irq` on the next cycle.
- R6: `wake_irq` is sticky. It stays 1 across the self-clear of `armed` and across any idle cycles until a read strobe.
- R7: A rising edge seen while armed, before any falling edge, leaves `armed` at 1.
- R8: A cycle with `arm_wr`=1 and `arm_val`=0 returns the monitor to disarmed on the next cycle from any state. A falling edge in that same cycle raises no interrupt.
- R9: If the line is low when the monitor is armed, no interrupt is raised until the line has gone high and then fallen.
- R10: Falling edges while the monitor is disarmed do not set `wake_irq`.
- R11: When a wake event and a read strobe fall in the same cycle, `wake_irq` is 1 afterwards. Setting wins over clearing.
- R12: A falling edge in the same cycle as the arming write is not counted as a wake event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_sync | input | 1 | Receive line, already synchronized to clk, idle high |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_val | input | 1 | Value written to the arm bit (1 arm, 0 abort) |
| rd_stb | input | 1 | Receive data register read strobe, clears the flag |
| wake_irq | output | 1 | Sticky wake-up interrupt flag |
| armed | output | 1 | Arm bit status, 1 while monitoring or waiting for the end of the break |
| rx_inhibit | output | 1 | Holds the normal character receiver idle |

## Verification
Two collisions can occur in one cycle. A wake event can meet the read strobe, and a line edge can meet a write to the arm bit. The scoreboard provokes a fall together with `rd_stb` and expects the flag to remain set. It drives a fall in the same cycle as an arming write and in the same cycle as an abort write, and in both cases expects no flag. It also drives a read together with a rising edge and expects the flag cleared while the monitor disarms.

// File: rtl/brk_wake_pkg.sv
package brk_wake_pkg;

    typedef enum logic [1:0] {
        WK_DISARMED  = 2'd0,
        WK_WAIT_FALL = 2'd1,
        WK_WAIT_RISE = 2'd2
    } wk_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } wk_edge_t;

    typedef struct packed {
        logic set_req;
        logic clr_req;
    } wk_arm_cmd_t;

    function automatic wk_edge_t wk_find_edges(input logic now_lvl, input logic prev_lvl);
        wk_edge_t e;
        e.rise = now_lvl & ~prev_lvl;
        e.fall = ~now_lvl & prev_lvl;
        return e;
    endfunction

    function automatic wk_state_e wk_next(input wk_state_e cur,
                                          input wk_arm_cmd_t cmd,
                                          input wk_edge_t e);
        wk_state_e nxt;
        nxt = cur;
        if (cmd.clr_req) begin
            nxt = WK_DISARMED;
        end else begin
            case (cur)
                WK_DISARMED:  if (cmd.set_req) nxt = WK_WAIT_FALL;
                WK_WAIT_FALL: if (e.fall)      nxt = WK_WAIT_RISE;
                WK_WAIT_RISE: if (e.rise)      nxt = WK_DISARMED;
                default:                       nxt = WK_DISARMED;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/wk_edge_detect.sv
module wk_edge_detect
    import brk_wake_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_in,
    output logic     prev_lvl,
    output wk_edge_t edges
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= IDLE_LEVEL;
        end else begin
            prev_lvl <= line_in;
        end
    end

    always_comb begin
        edges = wk_find_edges(line_in, prev_lvl);
    end

endmodule

// File: rtl/wk_arm_fsm.sv
module wk_arm_fsm
    import brk_wake_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wk_arm_cmd_t cmd,
    input  wk_edge_t    edges,
    output wk_state_e   state,
    output logic        wake_evt
);

    wk_state_e state_nxt;

    always_comb begin
        state_nxt = wk_next(state, cmd, edges);
        wake_evt  = (state == WK_WAIT_FALL) && edges.fall && !cmd.clr_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WK_DISARMED;
        end else begin
            state <= state_nxt;
        end
    end

endmodule

// File: rtl/wk_irq_flag.sv
module wk_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_evt) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/brk_wake_monitor.sv
module brk_wake_monitor
    import brk_wake_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_sync,
    input  logic arm_wr,
    input  logic arm_val,
    input  logic rd_stb,
    output logic wake_irq,
    output logic armed,
    output logic rx_inhibit
);

    wk_edge_t    edges;
    logic        rx_prev;
    wk_arm_cmd_t cmd;
    wk_state_e   state;
    logic        wake_evt;

    always_comb begin
        cmd.set_req = arm_wr & arm_val;
        cmd.clr_req = arm_wr & ~arm_val;
    end

    wk_edge_detect #(.IDLE_LEVEL(IDLE_LEVEL)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .line_in  (rx_sync),
        .prev_lvl (rx_prev),
        .edges    (edges)
    );

    wk_arm_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .edges    (edges),
        .state    (state),
        .wake_evt (wake_evt)
    );

    wk_irq_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (wake_evt),
        .clr_evt (rd_stb),
        .flag    (wake_irq)
    );

    assign armed      = (state != WK_DISARMED);
    assign rx_inhibit = armed;

endmodule

// File: rtl/brk_wake_monitor_chk.sv
module brk_wake_monitor_chk
    import brk_wake_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      rx_sync,
    input logic      rx_prev,
    input logic      arm_wr,
    input logic      arm_val,
    input logic      rd_stb,
    input logic      wake_irq,
    input logic      armed,
    input logic      rx_inhibit,
    input wk_state_e state
);

    logic ev_now;
    assign ev_now = (state == WK_WAIT_FALL) && rx_prev && !rx_sync && !(arm_wr && !arm_val);

    a_r2_arm_takes: assert property (@(posedge clk) disable iff (rst)
        (!armed && arm_wr && arm_val) |=> (armed && rx_inhibit));

    a_r3_fall_raises: assert property (@(posedge clk) disable iff (rst)
        ev_now |=> (wake_irq && armed));

    a_r4_self_clear: assert property (@(posedge clk) disable iff (rst)
        (state == WK_WAIT_RISE && !rx_prev && rx_sync && !arm_wr) |=> !armed);

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !ev_now) |=> !wake_irq);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (wake_irq && !rd_stb) |=> wake_irq);

    a_r8_abort: assert property (@(posedge clk) disable iff (rst)
        (arm_wr && !arm_val && !wake_irq) |=> (!armed && !wake_irq));

    a_r10_rise_source: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_irq) |-> ($past(state) == WK_WAIT_FALL));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ev_now && rd_stb) |=> wake_irq);

endmodule

bind brk_wake_monitor brk_wake_monitor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_sync    (rx_sync),
    .rx_prev    (rx_prev),
    .arm_wr     (arm_wr),
    .arm_val    (arm_val),
    .rd_stb     (rd_stb),
    .wake_irq   (wake_irq),
    .armed      (armed),
    .rx_inhibit (rx_inhibit),
    .state      (state)
);

// File: tb/brk_wake_monitor_bench.sv
`timescale 1ns/1ps
module brk_wake_monitor_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_sync = 1'b1;
    logic arm_wr = 1'b0;
    logic arm_val = 1'b0;
    logic rd_stb = 1'b0;
    logic wake_irq, armed, rx_inhibit;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  irq;
        logic  arm;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    brk_wake_monitor u_brk_wake_monitor (
        .clk        (clk),
        .rst        (rst),
        .rx_sync    (rx_sync),
        .arm_wr     (arm_wr),
        .arm_val    (arm_val),
        .rd_stb     (rd_stb),
        .wake_irq   (wake_irq),
        .armed      (armed),
        .rx_inhibit (rx_inhibit)
    );

    task automatic compare(input logic e_irq, input logic e_arm, input string tag);
        n_checks++;
        if (wake_irq !== e_irq || armed !== e_arm || rx_inhibit !== e_arm) begin
            n_fails++;
            $display("FAIL %s: irq/armed/inhibit = %b/%b/%b expected %b/%b/%b",
                     tag, wake_irq, armed, rx_inhibit, e_irq, e_arm, e_arm);
        end
    endtask

    // monitor: compares one expected item per negedge once results are due
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            compare(it.irq, it.arm, it.tag);
        end
    end

    // driver: apply one cycle of stimulus, queue the state expected after the edge
    task automatic drive(input logic aw, input logic av, input logic rd, input logic rx,
                         input logic e_irq, input logic e_arm, input string tag);
        exp_t it;
        @(negedge clk);
        arm_wr  = aw;
        arm_val = av;
        rd_stb  = rd;
        rx_sync = rx;
        @(posedge clk);
        #1;
        it.irq = e_irq;
        it.arm = e_arm;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(1'b0, 1'b0, "R1 reset");
        rst = 1'b0;

        drive(0,0,0,1, 0,0, "R1 idle after reset");
        drive(0,0,0,0, 0,0, "R10 fall while disarmed");
        drive(0,0,0,1, 0,0, "R10 rise while disarmed");
        drive(1,1,0,1, 0,1, "R2 arm");
        drive(0,0,0,0, 1,1, "R3 fall raises flag");
        drive(0,0,0,0, 1,1, "R6 low break holds");
        drive(0,0,0,1, 1,0, "R4 rise disarms, R6 flag kept");
        drive(0,0,0,1, 1,0, "R6 flag sticky idle");
        drive(0,0,1,1, 0,0, "R5 read clears");

        drive(0,0,0,0, 0,0, "R10 fall disarmed");
        drive(1,1,0,0, 0,1, "R9 arm while low");
        drive(0,0,0,0, 0,1, "R9 still low no event");
        drive(0,0,0,1, 0,1, "R7 rise before fall stays armed");
        drive(0,0,0,0, 1,1, "R9 fall after high");
        drive(0,0,1,0, 0,1, "R5 read during break");
        drive(0,0,0,1, 0,0, "R4 rise disarms");

        drive(1,1,0,1, 0,1, "R2 arm");
        drive(1,0,0,0, 0,0, "R8 abort with fall");
        drive(0,0,0,1, 0,0, "R8 stays disarmed");

        drive(1,1,0,0, 0,1, "R12 arm with fall");
        drive(0,0,0,0, 0,1, "R12 no event");
        drive(0,0,0,1, 0,1, "R7 rise while waiting");
        drive(0,0,0,0, 1,1, "R3 fall raises");
        drive(0,0,1,1, 0,0, "R4 rise with read");

        drive(1,1,0,1, 0,1, "R2 arm");
        drive(0,0,0,0, 1,1, "R3 fall raises");
        drive(1,0,0,0, 1,0, "R8 abort in break keeps flag");
        drive(0,0,0,1, 1,0, "R6 flag kept");

        drive(1,1,1,1, 0,1, "R2 arm with read");
        drive(0,0,1,0, 1,1, "R11 event and read together");
        drive(0,0,0,1, 1,0, "R4 rise disarms");
        drive(0,0,0,1, 1,0, "R6 flag kept");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule